// File: doc/BRIEF.md
# Per-Pin Configurable Microcontroller Port

This block is an eight-pin peripheral port attached to a microcontroller's local bus. Each pin is set up on its own. As a general-purpose pin it is an input, or it is an output that shows a bit held in a data register. In address mode it instead drives one bit of the low-order address byte. That byte is taken from the multiplexed address/data bus by an internal latch that closes when the address-latch-enable strobe falls. Address mode removes the need for an external address latch when nearby devices need the low address bits held steady.

Software reaches four registers through a simple synchronous write strobe with a two-bit offset, and reads them back through a combinational read path. The four registers are the pad-level register, direction, data and address-mode select. The pad-level register always returns the level actually present on each pad after a two-flop synchronizer, whether the port or an outside source drives that pad. Each pad is modelled as separate input, output and output-enable vectors. A parameter mask, fixed when the block is built, makes chosen pins open-drain instead of push-pull.

Top module: `cfg_io_port`

## Requirements
- R1: After reset the direction, data and address-mode registers read 0 and every pad_oe bit is 0, so all pins are inputs.
- R2: On a push-pull pin whose address-mode bit is 0, direction bit 1 gives pad_oe 1 and a pad_out equal to the data-register bit. Direction bit 0 gives pad_oe 0.
- R3: A write at offset 1 (direction), 2 (data) or 3 (address-mode) is visible on a read of the same offset in the cycle after the write edge.
- R4: A read at offset 0 returns each pad's input level as sampled through two flops. An input pin reports the level driven from outside.
- R5: A write at offset 0 changes no register and no pad output.
- R6: The address latch loads the multiplexed bus byte that was present in the last clock cycle with address-latch-enable high, on the first clock edge at which that strobe is seen low. At all other times the latch holds its value, whatever the bus does.
- R7: A pin whose address-mode bit is 1 drives latched address bit n on pin n, whatever its direction and data bits hold.
- R8: A pin selected in the OD_MASK parameter never drives high. It has pad_oe 1 with pad_out 0 when its driven value is 0, and pad_oe 0 when that value is 1.
- R9: When the port drives a pin, offset 0 reads back the level the port itself drives on that pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset: 0 pad level, 1 direction, 2 data, 3 address mode |
| bus_wdata | input | PW | Write data |
| bus_rdata | output | PW | Read data for bus_addr (combinational) |
| ad_bus | input | PW | Multiplexed address/data byte |
| ale | input | 1 | Address-latch-enable strobe |
| pad_in | input | PW | Level present on each pad |
| pad_out | output | PW | Value driven on each pad |
| pad_oe | output | PW | Output enable for each pad |

## Verification
On every cycle the assertions check several things. Push-pull pins in register mode follow the data register, and open-drain pins release for a one and pull down for a zero. Every address-mode push-pull pin is enabled. Writes at the read-only offset leave all registers unchanged. The address latch loads only on a falling strobe and holds at all other times. The sweeps are the only check of the values a pin drives when address mode and register mode are mixed across many patterns. They also check, at the bus, the level that is read back from pads driven from outside or by the port itself, after the synchronizer delay. Reset values and register readback are checked there too.

// File: rtl/port_pkg.sv
package port_pkg;
  typedef enum logic [1:0] {
    REG_PIN   = 2'd0,
    REG_DIR   = 2'd1,
    REG_DATA  = 2'd2,
    REG_AMODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/port_regs.sv
module port_regs
  import port_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] dir_q,
  output logic [PW-1:0] data_q,
  output logic [PW-1:0] amode_q
);
  logic [PW-1:0] dir_n, data_n, amode_n;

  always_comb begin
    dir_n   = dir_q;
    data_n  = data_q;
    amode_n = amode_q;
    if (we) begin
      case (reg_sel_e'(sel))
        REG_DIR:   dir_n   = wdata;
        REG_DATA:  data_n  = wdata;
        REG_AMODE: amode_n = wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      data_q  <= '0;
      amode_q <= '0;
    end else begin
      dir_q   <= dir_n;
      data_q  <= data_n;
      amode_q <= amode_n;
    end
  end

  // R5: the pad-level offset is read-only
  p_pin_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd0) |=> ($stable(dir_q) && $stable(data_q) && $stable(amode_q)));

  // R3: a direction write lands in the next cycle
  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd1) |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/port_addr_latch.sv
module port_addr_latch #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [PW-1:0] ad_bus,
  output logic [PW-1:0] addr_q
);
  logic          ale_d;
  logic [PW-1:0] ad_d;
  logic          fall;
  logic [PW-1:0] addr_n;

  assign fall = ale_d & ~ale;

  always_comb begin
    addr_n = addr_q;
    if (fall) addr_n = ad_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d  <= 1'b0;
      ad_d   <= '0;
      addr_q <= '0;
    end else begin
      ale_d  <= ale;
      ad_d   <= ad_bus;
      addr_q <= addr_n;
    end
  end

  // R6: load only on the trailing strobe edge
  p_latch_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_d && !ale) |=> (addr_q == $past(ad_d)));

  // R6: hold otherwise
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_d && !ale) |=> $stable(addr_q));
endmodule

// File: rtl/port_sync2.sv
module port_sync2 #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q
);
  logic [PW-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/port_pad_drive.sv
module port_pad_drive #(
  parameter int          PW      = 8,
  parameter logic [PW-1:0] OD_MASK = '0
) (
  input  logic [PW-1:0] dir,
  input  logic [PW-1:0] data,
  input  logic [PW-1:0] amode,
  input  logic [PW-1:0] addr,
  output logic [PW-1:0] pad_out,
  output logic [PW-1:0] pad_oe
);
  for (genvar i = 0; i < PW; i++) begin : g_pin
    logic val;
    logic drv;
    assign val = amode[i] ? addr[i] : data[i];
    assign drv = amode[i] | dir[i];
    if (OD_MASK[i]) begin : g_od
      assign pad_out[i] = 1'b0;
      assign pad_oe[i]  = drv & ~val;
    end else begin : g_pp
      assign pad_out[i] = val;
      assign pad_oe[i]  = drv;
    end
  end
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import port_pkg::*;
#(
  parameter int            PW      = 8,
  parameter logic [PW-1:0] OD_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [PW-1:0] bus_wdata,
  output logic [PW-1:0] bus_rdata,
  input  logic [PW-1:0] ad_bus,
  input  logic          ale,
  input  logic [PW-1:0] pad_in,
  output logic [PW-1:0] pad_out,
  output logic [PW-1:0] pad_oe
);
  localparam logic [PW-1:0] PP_MASK = ~OD_MASK;

  logic [1:0]    rst_sr;
  logic          rst_s;
  logic [PW-1:0] dir_q, data_q, amode_q, addr_q, pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_s = rst_sr[1];

  port_regs #(.PW(PW)) i_regs (
    .clk(clk), .rst_n(rst_s), .we(bus_we), .sel(bus_addr), .wdata(bus_wdata),
    .dir_q(dir_q), .data_q(data_q), .amode_q(amode_q)
  );

  port_addr_latch #(.PW(PW)) i_alat (
    .clk(clk), .rst_n(rst_s), .ale(ale), .ad_bus(ad_bus), .addr_q(addr_q)
  );

  port_sync2 #(.PW(PW)) i_sync (
    .clk(clk), .rst_n(rst_s), .d(pad_in), .q(pin_q)
  );

  port_pad_drive #(.PW(PW), .OD_MASK(OD_MASK)) i_drive (
    .dir(dir_q), .data(data_q), .amode(amode_q), .addr(addr_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_PIN:   bus_rdata = pin_q;
      REG_DIR:   bus_rdata = dir_q;
      REG_DATA:  bus_rdata = data_q;
      default:   bus_rdata = amode_q;
    endcase
  end

  // R2: push-pull register-mode pins follow direction and data
  p_pp_follow_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (((pad_oe ^ dir_q) & PP_MASK & ~amode_q) == '0) &&
    (((pad_out ^ data_q) & PP_MASK & ~amode_q & dir_q) == '0));

  // R8: open-drain register-mode outputs release for one, pull low for zero
  p_od_release_r8: assert property (@(posedge clk) disable iff (!rst_s)
    ((pad_oe ^ (dir_q & ~data_q)) & OD_MASK & ~amode_q) == '0);

  // R7: address-mode push-pull pins always drive the latched bit
  p_amode_drive_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (((amode_q & PP_MASK & ~pad_oe) == '0) &&
     (((pad_out ^ addr_q) & amode_q & PP_MASK) == '0)));
endmodule

// File: tb/test_cfg_io_port.sv
module test_cfg_io_port;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam logic [PW-1:0] ODM = 8'hF0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_we;
  logic [1:0]    bus_addr;
  logic [PW-1:0] bus_wdata, bus_rdata, ad_bus, pad_in, pad_out, pad_oe;
  logic          ale;
  logic [PW-1:0] ext_en, ext_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ((ext_en & ext_val) | ~ext_en));

  cfg_io_port #(.PW(PW), .OD_MASK(ODM)) i_cfg_io_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ad_bus(ad_bus), .ale(ale),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [PW-1:0] e_oe(logic [PW-1:0] d, logic [PW-1:0] v,
                                         logic [PW-1:0] m, logic [PW-1:0] a);
    logic [PW-1:0] r;
    for (int i = 0; i < PW; i++) begin
      logic val, drv;
      val = m[i] ? a[i] : v[i];
      drv = m[i] | d[i];
      r[i] = ODM[i] ? (drv & ~val) : drv;
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] e_lvl(logic [PW-1:0] d, logic [PW-1:0] v,
                                          logic [PW-1:0] m, logic [PW-1:0] a,
                                          logic [PW-1:0] xe, logic [PW-1:0] xv);
    logic [PW-1:0] r;
    logic [PW-1:0] oe;
    oe = e_oe(d, v, m, a);
    for (int i = 0; i < PW; i++) begin
      logic val;
      val = m[i] ? a[i] : v[i];
      if (oe[i])     r[i] = ODM[i] ? 1'b0 : val;
      else if (xe[i]) r[i] = xv[i];
      else           r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [PW-1:0] v);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [PW-1:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic latch_addr(logic [PW-1:0] a);
    ale = 1'b1; ad_bus = a;
    @(negedge clk);
    ale = 1'b0; ad_bus = ~a;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [PW-1:0] r, dv, vv, mv, av, lat;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    ad_bus = '0; ale = 1'b0; ext_en = '0; ext_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    rd(2'd1, r); chk("R1 dir", r, 8'h00);
    rd(2'd2, r); chk("R1 data", r, 8'h00);
    rd(2'd3, r); chk("R1 amode", r, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    rd(2'd0, r); chk("R4 pull-up level", r, 8'hFF);

    // Register-mode sweep over all direction patterns: R2, R3, R4, R8, R9
    for (int k = 0; k < 256; k++) begin
      dv = 8'(k); vv = 8'(k * 37 + 11);
      ext_en = 8'hFF; ext_val = 8'(k) ^ 8'hC3;
      wr(2'd1, dv);
      wr(2'd2, vv);
      rd(2'd1, r); chk("R3 dir readback", r, dv);
      rd(2'd2, r); chk("R3 data readback", r, vv);
      chk("R2/R8 pad_oe", pad_oe, e_oe(dv, vv, 8'h00, 8'h00));
      chk("R2 pp pad_out", pad_out & pad_oe & ~ODM, vv & dv & ~ODM);
      chk("R8 od pad_out", pad_out & ODM, 8'h00);
      repeat (3) @(negedge clk);
      rd(2'd0, r);
      chk("R4/R9 pad level", r, e_lvl(dv, vv, 8'h00, 8'h00, ext_en, ext_val));
    end

    // Address-mode sweep: R6, R7
    dv = 8'h0F; vv = 8'h33;
    wr(2'd1, dv);
    wr(2'd2, vv);
    ext_en = 8'h00;
    for (int k = 0; k < 256; k++) begin
      mv = 8'(k); av = 8'(k * 91 + 5);
      wr(2'd3, mv);
      rd(2'd3, r); chk("R3 amode readback", r, mv);
      latch_addr(av);
      lat = av;
      chk("R6/R7 pad_oe", pad_oe, e_oe(dv, vv, mv, lat));
      chk("R7 pp pad_out", pad_out & pad_oe & ~ODM, e_lvl(dv, vv, mv, lat, 8'h00, 8'h00) & pad_oe & ~ODM);
      // bus activity without the strobe must not move the latch
      ad_bus = 8'(k * 13 + 7);
      repeat (2) @(negedge clk);
      chk("R6 hold pad_oe", pad_oe, e_oe(dv, vv, mv, lat));
      chk("R6 hold pad_out", pad_out & ~ODM & mv, lat & ~ODM & mv);
      rd(2'd0, r);
      chk("R9 pad level", r, e_lvl(dv, vv, mv, lat, 8'h00, 8'h00));
    end

    // R5: writes to the read-only offset change nothing
    wr(2'd3, 8'hA5);
    latch_addr(8'h3C);
    r = pad_oe; lat = pad_out;
    wr(2'd0, 8'hFF);
    wr(2'd0, 8'h00);
    rd(2'd1, dv); chk("R5 dir kept", dv, 8'h0F);
    rd(2'd2, vv); chk("R5 data kept", vv, 8'h33);
    rd(2'd3, mv); chk("R5 amode kept", mv, 8'hA5);
    chk("R5 pad_oe kept", pad_oe, r);
    chk("R5 pad_out kept", pad_out, lat);

    finish_run();
  end
endmodule